// File: doc/BRIEF.md
# Edge-Triggered Signed Up/Down Event Counter

This block counts events that arrive as level signals on two separate lines, one that adds and one that subtracts. A step is taken only when a line goes from low to high. Holding a line high, or letting it fall, leaves the count alone. The running count is a signed 16-bit value. The block compares it against a loadable signed threshold and raises a done flag whenever the count has reached or passed that threshold.

Counting past either end of the signed range wraps the count round to the other end. The wrap also sets a sticky flag for that direction. A clear command zeroes the count and drops both wrap flags. The threshold is left untouched.

All status is also gathered into one 16-bit control word at fixed bit positions, so that a neighbour can decode it without extra wiring. The block suits event tallies, batch counts and position counts fed by slow, debounced sensor or button signals.

Top module: `edge_updown_counter`

## Requirements
- R1: Each low-to-high transition of `up_en` adds one to `acc_q` at the clock edge where `up_en` is first sampled high. Further cycles with `up_en` held high add nothing.
- R2: Each low-to-high transition of `dn_en` subtracts one from `acc_q` at the clock edge where `dn_en` is first sampled high. Further cycles with `dn_en` held high subtract nothing.
- R3: In a cycle where neither enable rises and `clr_cmd` is low, `acc_q` keeps its value. This includes cycles where an enable falls.
- R4: If both enables rise at the same clock edge, the two steps cancel and `acc_q` is unchanged.
- R5: `preset_wr` loads `preset_in` into the threshold at the clock edge. `done` is 1 exactly when `acc_q` is greater than or equal to the threshold, with both taken as signed 16-bit values.
- R6: An up step from 32767 gives -32768 and sets the overflow flag. The flag stays set until a clear or reset.
- R7: A down step from -32768 gives 32767 and sets the underflow flag. The flag stays set until a clear or reset.
- R8: `clr_cmd` zeroes `acc_q` and both wrap flags at the clock edge. It wins over any enable edge in that cycle and keeps the threshold.
- R9: Control word layout: bit 15 is the registered copy of `up_en`, bit 14 the registered copy of `dn_en`, bit 13 done, bit 12 overflow, bit 11 underflow, bit 10 the update flag. Bits 9 down to 0 read as zero.
- R10: Synchronous reset `rst` zeroes the count, the threshold, both wrap flags, the update flag and both registered enable copies. `done` then reads 1, because 0 is greater than or equal to 0.
- R11: The update flag (control word bit 10) is 1 for exactly the one cycle after an edge where `acc_q` took a step. Otherwise it is 0, including after a cancelled pair and after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_en | input | 1 | Count-up line, acts on its rising transition |
| dn_en | input | 1 | Count-down line, acts on its rising transition |
| clr_cmd | input | 1 | Clear command for the count and the wrap flags |
| preset_wr | input | 1 | Load strobe for the threshold |
| preset_in | input | 16 | Signed threshold value |
| acc_q | output | 16 | Signed running count |
| ctrl_word | output | 16 | Packed control and status word |
| done | output | 1 | Count has reached or passed the threshold |

## Verification
A stale registered enable copy shows up at the ports in one of two ways. Bits 15 or 14 of the control word lag by an extra cycle, or `acc_q` steps twice for one press. Either is visible at the first edge after the fault. A wrong accumulator or threshold register shows at once through `done` and `acc_q`. A wrap flag that fails to stick, or fails to clear, shows in bits 12 or 11 on the next cycle. The bench compares every output against a behavioural model after every clock. It drives a full climb to the top of the range, then an overflow, then an underflow straight after it. A divergence is therefore caught within one cycle of its cause.

// File: rtl/edge_cnt_pkg.sv
package edge_cnt_pkg;

    localparam int CW_BITS = 16;
    localparam int CW_UP   = 15;
    localparam int CW_DN   = 14;
    localparam int CW_DONE = 13;
    localparam int CW_OVF  = 12;
    localparam int CW_UNF  = 11;
    localparam int CW_UPD  = 10;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_t;

    typedef struct packed {
        logic up_seen;
        logic dn_seen;
        logic done;
        logic ovf;
        logic unf;
        logic upd;
    } cnt_status_t;

    // Opposite edges at the same clock cancel out.
    function automatic step_t pick_step(input logic up_rise, input logic dn_rise);
        step_t s;
        if (up_rise && !dn_rise)
            s = STEP_INC;
        else if (dn_rise && !up_rise)
            s = STEP_DEC;
        else
            s = STEP_NONE;
        return s;
    endfunction

    function automatic logic [CW_BITS-1:0] pack_ctrl(input cnt_status_t s);
        logic [CW_BITS-1:0] w;
        w          = '0;
        w[CW_UP]   = s.up_seen;
        w[CW_DN]   = s.dn_seen;
        w[CW_DONE] = s.done;
        w[CW_OVF]  = s.ovf;
        w[CW_UNF]  = s.unf;
        w[CW_UPD]  = s.upd;
        return w;
    endfunction

endpackage

// File: rtl/rise_detect.sv
module rise_detect #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] prev,
    output logic [N-1:0] rise
);

    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                prev[i] <= 1'b0;
            else
                prev[i] <= lvl[i];
        end

        assign rise[i] = lvl[i] & ~prev[i];

        AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
            rise[i] |=> !rise[i]); // R1
    end

endmodule

// File: rtl/acc_core.sv
module acc_core
    import edge_cnt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  step_t        step,
    output logic [W-1:0] acc_q,
    output logic         ovf_q,
    output logic         unf_q,
    output logic         upd_q
);

    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] acc_d;
    logic         ovf_d;
    logic         unf_d;
    logic         upd_d;

    always_comb begin
        acc_d = acc_q;
        ovf_d = ovf_q;
        unf_d = unf_q;
        upd_d = 1'b0;
        if (clr) begin
            acc_d = '0;
            ovf_d = 1'b0;
            unf_d = 1'b0;
        end else begin
            case (step)
                STEP_INC: begin
                    acc_d = acc_q + ONE;
                    upd_d = 1'b1;
                    if (acc_q == MAXV) ovf_d = 1'b1;
                end
                STEP_DEC: begin
                    acc_d = acc_q - ONE;
                    upd_d = 1'b1;
                    if (acc_q == MINV) unf_d = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
            upd_q <= 1'b0;
        end else begin
            acc_q <= acc_d;
            ovf_q <= ovf_d;
            unf_q <= unf_d;
            upd_q <= upd_d;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!clr && step == STEP_NONE) |=> $stable(acc_q)); // R3
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_q == '0 && !ovf_q && !unf_q)); // R8
    AST_OVF_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!clr && step == STEP_INC && acc_q == MAXV) |=> (ovf_q && acc_q == MINV)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !clr) |=> ovf_q); // R6
    AST_UNF_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!clr && step == STEP_DEC && acc_q == MINV) |=> (unf_q && acc_q == MAXV)); // R7
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (unf_q && !clr) |=> unf_q); // R7
    AST_UPD_MEANS_MOVE: assert property (@(posedge clk) disable iff (rst)
        upd_q |-> (acc_q != $past(acc_q))); // R11

endmodule

// File: rtl/preset_cmp.sv
module preset_cmp #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] din,
    input  logic [W-1:0] acc,
    output logic         done
);

    logic [W-1:0] preset_q;

    always_ff @(posedge clk) begin
        if (rst)
            preset_q <= '0;
        else if (wr)
            preset_q <= din;
    end

    assign done = $signed(acc) >= $signed(preset_q);

    AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr |=> (preset_q == $past(din))); // R5
    AST_PRESET_KEEP: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(preset_q)); // R5

endmodule

// File: rtl/edge_updown_counter.sv
module edge_updown_counter
    import edge_cnt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         up_en,
    input  logic         dn_en,
    input  logic         clr_cmd,
    input  logic         preset_wr,
    input  logic [W-1:0] preset_in,
    output logic [W-1:0] acc_q,
    output logic [15:0]  ctrl_word,
    output logic         done
);

    localparam int NLINES = 2;
    localparam int UP_IX  = 0;
    localparam int DN_IX  = 1;

    logic [NLINES-1:0] lines;
    logic [NLINES-1:0] prev;
    logic [NLINES-1:0] rise;
    step_t             step;
    logic              ovf_q;
    logic              unf_q;
    logic              upd_q;
    cnt_status_t       st;

    assign lines[UP_IX] = up_en;
    assign lines[DN_IX] = dn_en;

    rise_detect #(.N(NLINES)) u_edges (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lines),
        .prev (prev),
        .rise (rise)
    );

    assign step = pick_step(rise[UP_IX], rise[DN_IX]);

    acc_core #(.W(W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_cmd),
        .step  (step),
        .acc_q (acc_q),
        .ovf_q (ovf_q),
        .unf_q (unf_q),
        .upd_q (upd_q)
    );

    preset_cmp #(.W(W)) u_cmp (
        .clk  (clk),
        .rst  (rst),
        .wr   (preset_wr),
        .din  (preset_in),
        .acc  (acc_q),
        .done (done)
    );

    always_comb begin
        st.up_seen = prev[UP_IX];
        st.dn_seen = prev[DN_IX];
        st.done    = done;
        st.ovf     = ovf_q;
        st.unf     = unf_q;
        st.upd     = upd_q;
    end

    assign ctrl_word = pack_ctrl(st);

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctrl_word[9:0] == 10'd0); // R9
    AST_UP_MIRROR: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ctrl_word[15] == $past(up_en))); // R9
    AST_PAIR_CANCEL: assert property (@(posedge clk) disable iff (rst)
        (up_en && !ctrl_word[15] && dn_en && !ctrl_word[14] && !clr_cmd) |=> $stable(acc_q)); // R4

endmodule

// File: tb/edge_updown_counter_test.sv
`timescale 1ns/1ps
module edge_updown_counter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        up_en = 1'b0;
    logic        dn_en = 1'b0;
    logic        clr_cmd = 1'b0;
    logic        preset_wr = 1'b0;
    logic [15:0] preset_in = 16'd0;
    logic [15:0] acc_q;
    logic [15:0] ctrl_word;
    logic        done;

    always #2 clk = ~clk;

    edge_updown_counter uut (
        .clk       (clk),
        .rst       (rst),
        .up_en     (up_en),
        .dn_en     (dn_en),
        .clr_cmd   (clr_cmd),
        .preset_wr (preset_wr),
        .preset_in (preset_in),
        .acc_q     (acc_q),
        .ctrl_word (ctrl_word),
        .done      (done)
    );

    // Behavioural reference state
    integer m_acc = 0, m_pre = 0;
    bit     m_ovf = 0, m_unf = 0, m_upd = 0, m_up = 0, m_dn = 0;
    integer vectors = 0, errors = 0;
    bit     finished = 0;
    string  tag = "R10";

    task automatic model_edge();
        bit ur, dr;
        if (rst) begin
            m_acc = 0; m_pre = 0; m_ovf = 0; m_unf = 0; m_upd = 0; m_up = 0; m_dn = 0;
        end else begin
            ur = up_en && !m_up;
            dr = dn_en && !m_dn;
            m_upd = 0;
            if (clr_cmd) begin
                m_acc = 0; m_ovf = 0; m_unf = 0;
            end else if (ur && !dr) begin
                m_upd = 1;
                if (m_acc == 32767) begin m_acc = -32768; m_ovf = 1; end
                else m_acc = m_acc + 1;
            end else if (dr && !ur) begin
                m_upd = 1;
                if (m_acc == -32768) begin m_acc = 32767; m_unf = 1; end
                else m_acc = m_acc - 1;
            end
            if (preset_wr) m_pre = $signed(preset_in);
            m_up = up_en;
            m_dn = dn_en;
        end
    endtask

    task automatic cyc();
        bit          e_done;
        logic [15:0] e_ctrl;
        @(posedge clk);
        model_edge();
        #1;
        e_done = (m_acc >= m_pre);
        e_ctrl = {m_up, m_dn, e_done, m_ovf, m_unf, m_upd, 10'd0};
        vectors++;
        if ($signed(acc_q) != m_acc || ctrl_word !== e_ctrl || done !== e_done) begin
            errors++;
            $display("FAIL %s acc=%0d exp %0d ctrl=%h exp %h done=%b exp %b",
                     tag, $signed(acc_q), m_acc, ctrl_word, e_ctrl, done, e_done);
        end
    endtask

    task automatic pulse_up();
        up_en = 1'b1; cyc(); up_en = 1'b0; cyc();
    endtask

    task automatic pulse_dn();
        dn_en = 1'b1; cyc(); dn_en = 1'b0; cyc();
    endtask

    initial begin
        #1;
        tag = "R10"; cyc(); cyc();
        rst = 1'b0; cyc();

        tag = "R1";  pulse_up(); pulse_up(); pulse_up();
        up_en = 1'b1; repeat (4) cyc();           // held level: no extra counts
        tag = "R3";  up_en = 1'b0; repeat (3) cyc();
        tag = "R2";  pulse_dn(); pulse_dn();
        dn_en = 1'b1; repeat (3) cyc(); dn_en = 1'b0; cyc();

        tag = "R4";  up_en = 1'b1; dn_en = 1'b1; cyc(); cyc();
        up_en = 1'b0; dn_en = 1'b0; cyc();
        tag = "R11"; up_en = 1'b1; cyc(); cyc(); up_en = 1'b0; cyc();

        tag = "R5";  preset_in = 16'd3; preset_wr = 1'b1; cyc(); preset_wr = 1'b0; cyc();
        pulse_up(); pulse_up(); pulse_dn();
        preset_in = 16'hFFFE; preset_wr = 1'b1; cyc(); preset_wr = 1'b0; cyc();
        repeat (4) pulse_dn();

        tag = "R8";  clr_cmd = 1'b1; up_en = 1'b1; cyc(); clr_cmd = 1'b0; up_en = 1'b0; cyc();

        tag = "R6";  preset_in = 16'h7FFF; preset_wr = 1'b1; cyc(); preset_wr = 1'b0;
        repeat (32767) pulse_up();
        pulse_up(); pulse_up();
        tag = "R7";  pulse_dn(); pulse_dn(); pulse_dn(); pulse_up();
        tag = "R9";  up_en = 1'b1; dn_en = 1'b1; cyc(); up_en = 1'b0; cyc(); dn_en = 1'b0; cyc();
        tag = "R8";  clr_cmd = 1'b1; dn_en = 1'b1; cyc(); clr_cmd = 1'b0; dn_en = 1'b0; cyc(); cyc();
        tag = "R10"; pulse_up(); rst = 1'b1; cyc(); rst = 1'b0; cyc();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired acc=%0d exp finished", $signed(acc_q));
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule